// File: doc/BRIEF.md
# Region-Decoding Memory Access Router

This block sits between a core's load/store/fetch port and a set of memory targets. It keeps a small table of address windows, each described by a base, a byte length and a target code. The table is always kept sorted by base. Every data access is forwarded to the first window that contains its address. If no window contains the address, the access goes to the default main memory. Instruction fetches never consult the table and always go to main memory.

One possible target is a tightly coupled memory held inside the block. In the usual configuration it is placed as a 32 KiB window at 0x10000000. It is addressed by the offset from its window base and it never reports an error.

The router also screens stores for misalignment. It turns errors reported by a target into trap cause codes, which it presents on a fault output together with the faulting address. Only one access is in flight at a time. Each forwarded access is presented to exactly one target through a request/ready/response handshake.

Top module: `mem_router`

## Requirements
- R1: After reset the region table is empty, `acc_ready_o` is high, `rsp_valid_o` and `trap_valid_o` are low, and every data access is served by main memory.
- R2: A table write (`cfg_we_i`) inserts the region in ascending base order, placing it after every existing region whose base is equal or lower. Among regions with equal bases, the one written first therefore matches first. A write made while the table already holds DEPTH regions is ignored.
- R3: An address hits a region when base <= addr < base + size. The hitting region that is earliest in table order selects the target. Target code k (0 <= k < N_EXT) selects external port k, code N_EXT selects the internal tightly coupled memory, and larger codes select main memory.
- R4: A load or store that hits no region is forwarded to main memory.
- R5: An access with `acc_fetch_i` high is forwarded to main memory whatever the table holds.
- R6: A store of more than one byte (`acc_size_i` 0=1 byte, 1=2 bytes, 2=4 bytes) whose address is not a multiple of its length is not forwarded. The next cycle it completes with `rsp_err_o` and a trap of cause 6 carrying the address. An access with `acc_dbg_i` high is exempt from this check, and loads are never checked.
- R7: An error response from a target raises cause 5 for a load or fetch and cause 7 for a store. In both cases `trap_addr_o` holds the access address and `rsp_err_o` is high.
- R8: The tightly coupled memory uses word index ((addr - region base) / 4) modulo TCM_WORDS. A store writes only the byte lanes starting at addr[1:0] for its length, dropping lanes beyond the word, and takes each byte from its own lane of the write data. A load returns the whole word. This target never signals an error.
- R9: `trap_valid_o` is high for exactly one cycle per faulting access. No new access is accepted while a response is being shown.
- R10: A forwarded access raises exactly one target request. With targets that are ready at once and respond on the next cycle, the response appears three clock edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Insert one region into the table |
| cfg_base_i | input | AW | Region base address |
| cfg_size_i | input | AW | Region length in bytes |
| cfg_tgt_i | input | TGT_W | Region target code |
| acc_valid_i | input | 1 | Access request valid |
| acc_ready_o | output | 1 | Router can accept an access |
| acc_addr_i | input | AW | Access byte address |
| acc_we_i | input | 1 | 1 = store, 0 = load |
| acc_fetch_i | input | 1 | Access is an instruction fetch |
| acc_dbg_i | input | 1 | Access is a debug access |
| acc_size_i | input | 2 | log2 of access length in bytes |
| acc_wdata_i | input | DW | Store data, lane aligned |
| rsp_valid_o | output | 1 | Access completed (one cycle) |
| rsp_err_o | output | 1 | Access completed with an error |
| rsp_rdata_o | output | DW | Load data |
| trap_valid_o | output | 1 | Fault raised (one cycle) |
| trap_cause_o | output | 4 | Fault cause code |
| trap_addr_o | output | AW | Faulting address |
| tgt_addr_o | output | AW | Address presented to the selected target |
| tgt_we_o | output | 1 | Store flag to the target |
| tgt_size_o | output | 2 | Size code to the target |
| tgt_wdata_o | output | DW | Store data to the target |
| mm_req_o | output | 1 | Main memory request |
| mm_ready_i | input | 1 | Main memory accepts request |
| mm_rsp_valid_i | input | 1 | Main memory response valid |
| mm_rsp_err_i | input | 1 | Main memory error |
| mm_rdata_i | input | DW | Main memory read data |
| ext_req_o | output | N_EXT | External region requests |
| ext_ready_i | input | N_EXT | External region accepts request |
| ext_rsp_valid_i | input | N_EXT | External response valid |
| ext_rsp_err_i | input | N_EXT | External error |
| ext_rdata_i | input | N_EXT*DW | External read data, port k at bits k*DW |

## Verification
An accepted access that the router forwards completes three clock edges after the accepting edge when the target is ready at once and responds one edge later. This holds for the internal memory as well. A rejected misaligned store completes, with its trap, one edge after acceptance. The trap must be gone one edge after that. The bench counts edges from the accepting edge, sampling on falling edges, and checks that the response arrives exactly at the expected count. It checks the trap fields at that same falling edge and their absence at the next. It also compares per-target request counts sampled before and after each access, which shows where the access was routed and that it was requested only once.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;
  typedef enum logic [1:0] {TK_MAIN, TK_TCM, TK_EXT} tk_e;

  localparam logic [3:0] CAUSE_LD_FAULT = 4'd5;
  localparam logic [3:0] CAUSE_ST_MISAL = 4'd6;
  localparam logic [3:0] CAUSE_ST_FAULT = 4'd7;

  // low address bits that must be zero for a naturally aligned access
  function automatic logic [2:0] align_mask(input logic [1:0] sz);
    return (3'd1 << sz) - 3'd1;
  endfunction
endpackage

// File: rtl/mrt_region_table.sv
module mrt_region_table #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int TGT_W = 2,
  parameter int OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [AW-1:0]    ins_base_i,
  input  logic [AW-1:0]    ins_size_i,
  input  logic [TGT_W-1:0] ins_tgt_i,
  input  logic [AW-1:0]    look_addr_i,
  output logic             hit_o,
  output logic [TGT_W-1:0] hit_tgt_o,
  output logic [OFF_W-1:0] hit_off_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    base_q [DEPTH];
  logic [AW-1:0]    size_q [DEPTH];
  logic [TGT_W-1:0] tgt_q  [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [CW-1:0]    pos;
  logic             full;

  // entries are packed low and sorted, so the slot is the count of bases <= new base
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && base_q[i] <= ins_base_i) pos = pos + CW'(1);
  end

  assign full = vld_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        tgt_q[i]  <= '0;
      end
    end else if (ins_i && !full) begin
      for (int i = DEPTH - 1; i >= 1; i--) begin
        if (CW'(i) > pos) begin
          base_q[i] <= base_q[i-1];
          size_q[i] <= size_q[i-1];
          tgt_q[i]  <= tgt_q[i-1];
          vld_q[i]  <= vld_q[i-1];
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == pos) begin
          base_q[i] <= ins_base_i;
          size_q[i] <= ins_size_i;
          tgt_q[i]  <= ins_tgt_i;
          vld_q[i]  <= 1'b1;
        end
      end
    end
  end

  // scan from the top so the lowest matching slot is assigned last and wins
  always_comb begin
    logic [AW-1:0] diff;
    hit_o     = 1'b0;
    hit_tgt_o = '0;
    hit_off_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      diff = look_addr_i - base_q[i];
      if (vld_q[i] && look_addr_i >= base_q[i] && diff < size_q[i]) begin
        hit_o     = 1'b1;
        hit_tgt_o = tgt_q[i];
        hit_off_o = diff[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mrt_tcm.sv
module mrt_tcm #(
  parameter int DW    = 32,
  parameter int WORDS = 1024
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] idx_i,
  input  logic [DW/8-1:0]          be_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     rsp_valid_o,
  output logic [DW-1:0]            rdata_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (req_i && we_i)
      for (int b = 0; b < NB; b++)
        if (be_i[b]) mem_q[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i && !we_i) rdata_o <= mem_q[idx_i];
    end
  end
endmodule

// File: rtl/mem_router.sv
module mem_router #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int DEPTH     = 4,
  parameter int N_EXT     = 2,
  parameter int TCM_WORDS = 1024,
  parameter int TGT_W     = $clog2(N_EXT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [AW-1:0]       cfg_base_i,
  input  logic [AW-1:0]       cfg_size_i,
  input  logic [TGT_W-1:0]    cfg_tgt_i,
  input  logic                acc_valid_i,
  output logic                acc_ready_o,
  input  logic [AW-1:0]       acc_addr_i,
  input  logic                acc_we_i,
  input  logic                acc_fetch_i,
  input  logic                acc_dbg_i,
  input  logic [1:0]          acc_size_i,
  input  logic [DW-1:0]       acc_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DW-1:0]       rsp_rdata_o,
  output logic                trap_valid_o,
  output logic [3:0]          trap_cause_o,
  output logic [AW-1:0]       trap_addr_o,
  output logic [AW-1:0]       tgt_addr_o,
  output logic                tgt_we_o,
  output logic [1:0]          tgt_size_o,
  output logic [DW-1:0]       tgt_wdata_o,
  output logic                mm_req_o,
  input  logic                mm_ready_i,
  input  logic                mm_rsp_valid_i,
  input  logic                mm_rsp_err_i,
  input  logic [DW-1:0]       mm_rdata_i,
  output logic [N_EXT-1:0]    ext_req_o,
  input  logic [N_EXT-1:0]    ext_ready_i,
  input  logic [N_EXT-1:0]    ext_rsp_valid_i,
  input  logic [N_EXT-1:0]    ext_rsp_err_i,
  input  logic [N_EXT*DW-1:0] ext_rdata_i
);
  import mrt_pkg::*;

  localparam int NB    = DW / 8;
  localparam int LW    = $clog2(NB);
  localparam int IW    = $clog2(TCM_WORDS);
  localparam int OFF_W = IW + LW;
  localparam int EW    = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  st_e              st_q;
  tk_e              kind_q;
  logic [EW-1:0]    ext_idx_q;
  logic [AW-1:0]    addr_q;
  logic             we_q;
  logic [1:0]       size_q;
  logic [DW-1:0]    wdata_q;
  logic [OFF_W-1:0] off_q;

  logic             rsp_valid_q, rsp_err_q, trap_valid_q;
  logic [DW-1:0]    rsp_rdata_q;
  logic [3:0]       trap_cause_q;
  logic [AW-1:0]    trap_addr_q;

  logic             hit;
  logic [TGT_W-1:0] hit_tgt;
  logic [OFF_W-1:0] hit_off;
  logic             accept, misal;
  tk_e              kind_d;
  logic [EW-1:0]    ext_idx_d;

  logic             sel_ready, sel_rsp_valid, sel_rsp_err;
  logic [DW-1:0]    sel_rdata;
  logic             tcm_req, tcm_rsp_valid;
  logic [DW-1:0]    tcm_rdata;
  logic [NB-1:0]    be;

  mrt_region_table #(
    .AW(AW), .DEPTH(DEPTH), .TGT_W(TGT_W), .OFF_W(OFF_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ins_i       (cfg_we_i),
    .ins_base_i  (cfg_base_i),
    .ins_size_i  (cfg_size_i),
    .ins_tgt_i   (cfg_tgt_i),
    .look_addr_i (acc_addr_i),
    .hit_o       (hit),
    .hit_tgt_o   (hit_tgt),
    .hit_off_o   (hit_off)
  );

  assign acc_ready_o = (st_q == ST_IDLE) && !rsp_valid_q;
  assign accept      = acc_valid_i && acc_ready_o;
  assign misal       = acc_we_i && !acc_dbg_i && (acc_size_i != 2'd0) &&
                       ((acc_addr_i[2:0] & align_mask(acc_size_i)) != 3'd0);

  always_comb begin
    kind_d    = TK_MAIN;
    ext_idx_d = '0;
    if (!acc_fetch_i && hit) begin
      if (hit_tgt == TGT_W'(N_EXT)) begin
        kind_d = TK_TCM;
      end else if (hit_tgt < TGT_W'(N_EXT)) begin
        kind_d    = TK_EXT;
        ext_idx_d = EW'(hit_tgt);
      end
    end
  end

  // target side
  assign tgt_addr_o  = addr_q;
  assign tgt_we_o    = we_q;
  assign tgt_size_o  = size_q;
  assign tgt_wdata_o = wdata_q;
  assign mm_req_o    = (st_q == ST_ISSUE) && (kind_q == TK_MAIN);
  assign tcm_req     = (st_q == ST_ISSUE) && (kind_q == TK_TCM);

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext_req
    assign ext_req_o[k] = (st_q == ST_ISSUE) && (kind_q == TK_EXT) && (ext_idx_q == EW'(k));
  end

  always_comb begin
    unique case (kind_q)
      TK_TCM: begin
        sel_ready     = 1'b1;
        sel_rsp_valid = tcm_rsp_valid;
        sel_rsp_err   = 1'b0;
        sel_rdata     = tcm_rdata;
      end
      TK_EXT: begin
        sel_ready     = ext_ready_i[ext_idx_q];
        sel_rsp_valid = ext_rsp_valid_i[ext_idx_q];
        sel_rsp_err   = ext_rsp_err_i[ext_idx_q];
        sel_rdata     = ext_rdata_i[ext_idx_q*DW +: DW];
      end
      default: begin
        sel_ready     = mm_ready_i;
        sel_rsp_valid = mm_rsp_valid_i;
        sel_rsp_err   = mm_rsp_err_i;
        sel_rdata     = mm_rdata_i;
      end
    endcase
  end

  // byte lanes of the stored bytes, lanes past the word are dropped
  always_comb begin
    int lo, n;
    lo = int'(addr_q[LW-1:0]);
    n  = 1 << size_q;
    for (int b = 0; b < NB; b++) be[b] = (b >= lo) && (b < lo + n);
  end

  mrt_tcm #(.DW(DW), .WORDS(TCM_WORDS)) u_tcm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (tcm_req),
    .we_i        (we_q),
    .idx_i       (off_q[OFF_W-1:LW]),
    .be_i        (be),
    .wdata_i     (wdata_q),
    .rsp_valid_o (tcm_rsp_valid),
    .rdata_o     (tcm_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      kind_q       <= TK_MAIN;
      ext_idx_q    <= '0;
      addr_q       <= '0;
      we_q         <= 1'b0;
      size_q       <= '0;
      wdata_q      <= '0;
      off_q        <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_err_q    <= 1'b0;
      rsp_rdata_q  <= '0;
      trap_valid_q <= 1'b0;
      trap_cause_q <= '0;
      trap_addr_q  <= '0;
    end else begin
      rsp_valid_q  <= 1'b0;
      trap_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q    <= acc_addr_i;
            we_q      <= acc_we_i;
            size_q    <= acc_size_i;
            wdata_q   <= acc_wdata_i;
            kind_q    <= kind_d;
            ext_idx_q <= ext_idx_d;
            off_q     <= hit_off;
            if (misal) begin
              rsp_valid_q  <= 1'b1;
              rsp_err_q    <= 1'b1;
              rsp_rdata_q  <= '0;
              trap_valid_q <= 1'b1;
              trap_cause_q <= CAUSE_ST_MISAL;
              trap_addr_q  <= acc_addr_i;
            end else begin
              st_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: if (sel_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (sel_rsp_valid) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= sel_rsp_err;
            rsp_rdata_q <= sel_rdata;
            if (sel_rsp_err) begin
              trap_valid_q <= 1'b1;
              trap_cause_q <= we_q ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
              trap_addr_q  <= addr_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_err_o    = rsp_err_q;
  assign rsp_rdata_o  = rsp_rdata_q;
  assign trap_valid_o = trap_valid_q;
  assign trap_cause_o = trap_cause_q;
  assign trap_addr_o  = trap_addr_q;
endmodule

// File: rtl/mem_router_chk.sv
module mem_router_chk #(
  parameter int AW    = 32,
  parameter int N_EXT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_ready_o,
  input logic [AW-1:0]    acc_addr_i,
  input logic             acc_we_i,
  input logic             acc_fetch_i,
  input logic             acc_dbg_i,
  input logic [1:0]       acc_size_i,
  input logic             rsp_valid_o,
  input logic             rsp_err_o,
  input logic             trap_valid_o,
  input logic [3:0]       trap_cause_o,
  input logic             mm_req_o,
  input logic [N_EXT-1:0] ext_req_o
);
  logic       acc_hs;
  logic [2:0] low_mask;
  logic       bad_store;

  assign acc_hs    = acc_valid_i && acc_ready_o;
  assign low_mask  = (3'd1 << acc_size_i) - 3'd1;
  assign bad_store = acc_we_i && !acc_dbg_i && (acc_size_i != 2'd0) &&
                     ((acc_addr_i[2:0] & low_mask) != 3'd0);

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mm_req_o, ext_req_o})); // R10

  AST_FETCH_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hs && acc_fetch_i |=> mm_req_o && (ext_req_o == '0)); // R5

  AST_MISALIGN_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_hs && bad_store |=> trap_valid_o && trap_cause_o == 4'd6 && !mm_req_o && (ext_req_o == '0)); // R6

  AST_TRAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |=> !trap_valid_o); // R9

  AST_NO_ACCEPT_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !acc_ready_o); // R9

  AST_TRAP_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> rsp_valid_o && rsp_err_o); // R7

  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> trap_cause_o inside {4'd5, 4'd6, 4'd7}); // R7
endmodule

bind mem_router mem_router_chk #(.AW(AW), .N_EXT(N_EXT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_ready_o  (acc_ready_o),
  .acc_addr_i   (acc_addr_i),
  .acc_we_i     (acc_we_i),
  .acc_fetch_i  (acc_fetch_i),
  .acc_dbg_i    (acc_dbg_i),
  .acc_size_i   (acc_size_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .trap_valid_o (trap_valid_o),
  .trap_cause_o (trap_cause_o),
  .mm_req_o     (mm_req_o),
  .ext_req_o    (ext_req_o)
);

// File: tb/mem_router_tb_top.sv
module mem_router_tb_top;
  localparam int AW = 32, DW = 32, DEPTH = 4, N_EXT = 2, TW = 64, TGT_W = 2;
  localparam logic [31:0] TCM_BASE = 32'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             cfg_we = 0;
  logic [AW-1:0]    cfg_base = 0, cfg_size = 0;
  logic [TGT_W-1:0] cfg_tgt = 0;
  logic             acc_valid = 0, acc_we = 0, acc_fetch = 0, acc_dbg = 0;
  logic [AW-1:0]    acc_addr = 0;
  logic [1:0]       acc_size = 0;
  logic [DW-1:0]    acc_wdata = 0;
  logic             acc_ready_o, rsp_valid_o, rsp_err_o, trap_valid_o, tgt_we_o;
  logic [DW-1:0]    rsp_rdata_o, tgt_wdata_o;
  logic [3:0]       trap_cause_o;
  logic [AW-1:0]    trap_addr_o, tgt_addr_o;
  logic [1:0]       tgt_size_o;
  logic             mm_req_o;
  logic             mm_rv = 0, mm_re = 0, mm_err = 0;
  logic [DW-1:0]    mm_rd = 0;
  logic [N_EXT-1:0] ext_req_o;
  logic [N_EXT-1:0] ext_rv = 0, ext_re = 0, ext_err = 0;
  logic [N_EXT*DW-1:0] ext_rd = 0;

  mem_router #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .N_EXT(N_EXT), .TCM_WORDS(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size), .cfg_tgt_i(cfg_tgt),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready_o), .acc_addr_i(acc_addr),
    .acc_we_i(acc_we), .acc_fetch_i(acc_fetch), .acc_dbg_i(acc_dbg),
    .acc_size_i(acc_size), .acc_wdata_i(acc_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
    .trap_valid_o(trap_valid_o), .trap_cause_o(trap_cause_o), .trap_addr_o(trap_addr_o),
    .tgt_addr_o(tgt_addr_o), .tgt_we_o(tgt_we_o), .tgt_size_o(tgt_size_o), .tgt_wdata_o(tgt_wdata_o),
    .mm_req_o(mm_req_o), .mm_ready_i(1'b1), .mm_rsp_valid_i(mm_rv), .mm_rsp_err_i(mm_re),
    .mm_rdata_i(mm_rd),
    .ext_req_o(ext_req_o), .ext_ready_i({N_EXT{1'b1}}), .ext_rsp_valid_i(ext_rv),
    .ext_rsp_err_i(ext_re), .ext_rdata_i(ext_rd)
  );

  // zero-wait target models with identifiable read data
  int n_mm = 0, n_e0 = 0, n_e1 = 0;
  always @(posedge clk) begin
    mm_rv <= mm_req_o;
    mm_re <= mm_req_o & mm_err;
    mm_rd <= ~tgt_addr_o;
    for (int k = 0; k < N_EXT; k++) begin
      ext_rv[k]            <= ext_req_o[k];
      ext_re[k]            <= ext_req_o[k] & ext_err[k];
      ext_rd[k*DW +: DW]   <= {8'(k + 1), tgt_addr_o[23:0]};
    end
    if (mm_req_o)     n_mm++;
    if (ext_req_o[0]) n_e0++;
    if (ext_req_o[1]) n_e1++;
  end

  int total = 0, bad = 0;
  logic done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side region model, in registration order
  logic [31:0] m_base [DEPTH];
  logic [31:0] m_size [DEPTH];
  int          m_tgt  [DEPTH];
  int          m_cnt = 0;
  logic [31:0] shw [TW];

  function automatic int exp_region(input logic [31:0] a, input bit fetch);
    int best = -1;
    if (fetch) return -1;
    for (int j = 0; j < m_cnt; j++)
      if (a >= m_base[j] && (a - m_base[j]) < m_size[j])
        if (best < 0 || m_base[j] < m_base[best]) best = j;
    return best;
  endfunction

  function automatic int exp_target(input logic [31:0] a, input bit fetch); // -1 main, 0..1 ext, 2 tcm
    int r = exp_region(a, fetch);
    if (r < 0) return -1;
    if (m_tgt[r] > N_EXT) return -1;
    return m_tgt[r];
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input bit fetch);
    int r = exp_region(a, fetch);
    int t = exp_target(a, fetch);
    if (t < 0) return ~a;
    if (t == N_EXT) return shw[((a - m_base[r]) >> 2) % TW];
    return {8'(t + 1), a[23:0]};
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int w = ((a - TCM_BASE) >> 2) % TW;
    int off = int'(a[1:0]);
    for (int i = 0; i < (1 << sz); i++)
      if (off + i < 4) shw[w][(off + i)*8 +: 8] = wd[(off + i)*8 +: 8];
  endtask

  task automatic cfg(input logic [31:0] b, input logic [31:0] s, input int t);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_size = s; cfg_tgt = TGT_W'(t);
    @(negedge clk);
    cfg_we = 0;
    if (m_cnt < DEPTH) begin
      m_base[m_cnt] = b; m_size[m_cnt] = s; m_tgt[m_cnt] = t; m_cnt++;
    end
  endtask

  int          r_lat, r_dmm, r_de0, r_de1;
  logic        r_err, r_tv, r_tv2, r_rdy;
  logic [31:0] r_rd, r_ta;
  logic [3:0]  r_tc;

  task automatic access(input logic [31:0] a, input bit we, input bit fetch, input bit dbg,
                        input logic [1:0] sz, input logic [31:0] wd);
    int s_mm, s_e0, s_e1;
    @(negedge clk);
    while (!acc_ready_o) @(negedge clk);
    s_mm = n_mm; s_e0 = n_e0; s_e1 = n_e1;
    acc_valid = 1; acc_addr = a; acc_we = we; acc_fetch = fetch; acc_dbg = dbg;
    acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0;
    r_lat = 1;
    while (!rsp_valid_o && r_lat < 20) begin
      @(negedge clk);
      r_lat++;
    end
    r_err = rsp_err_o; r_rd = rsp_rdata_o; r_tv = trap_valid_o;
    r_tc = trap_cause_o; r_ta = trap_addr_o; r_rdy = acc_ready_o;
    @(negedge clk);
    r_tv2 = trap_valid_o;
    r_dmm = n_mm - s_mm; r_de0 = n_e0 - s_e0; r_de1 = n_e1 - s_e1;
  endtask

  // load and check routing, data and request counts
  task automatic load_chk(input logic [31:0] a, input bit fetch, input string req);
    int t = exp_target(a, fetch);
    logic [31:0] e = exp_rdata(a, fetch);
    access(a, 1'b0, fetch, 1'b0, 2'd2, 32'h0);
    chk(r_lat == 3, {req, " latency R10"}, 32'(r_lat), 32'd3);
    chk(r_rd == e && !r_err, {req, " rdata"}, r_rd, e);
    chk(r_dmm == (t < 0 ? 1 : 0) && r_de0 == (t == 0 ? 1 : 0) && r_de1 == (t == 1 ? 1 : 0),
        {req, " target requests R10"}, {8'(r_dmm), 8'(r_de0), 8'(r_de1), 8'd0},
        {8'(t < 0 ? 1 : 0), 8'(t == 0 ? 1 : 0), 8'(t == 1 ? 1 : 0), 8'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_ready_o && !rsp_valid_o && !trap_valid_o && !mm_req_o && ext_req_o == 0,
        "R1 reset state", {28'd0, acc_ready_o, rsp_valid_o, trap_valid_o, mm_req_o}, 32'h8);
    rst_n = 1;
    for (int w = 0; w < TW; w++) shw[w] = 32'h0;

    // R1 R4: empty table sends everything to main memory
    load_chk(32'h1000_0000, 0, "R1 empty table");
    load_chk(32'hC000_0000, 0, "R4 empty table");

    // R2: registration with an equal-base duplicate placed later
    cfg(32'hC000_0000, 32'h0000_5000, 0);
    cfg(TCM_BASE,      32'h0000_8000, 2);
    cfg(32'h2000_0000, 32'h0000_0100, 1);
    cfg(32'hC000_0000, 32'h0000_0100, 1);
    cfg(32'h3000_0000, 32'h0000_1000, 1); // R2 table full, must be ignored

    // R8: clear tcm contents
    for (int w = 0; w < TW; w++) begin
      access(TCM_BASE + 32'(w*4), 1'b1, 0, 0, 2'd2, 32'h0);
      if (w == 0) chk(r_lat == 3 && !r_err && r_dmm == 0 && r_de0 == 0 && r_de1 == 0,
                      "R8 tcm store", 32'(r_lat), 32'd3);
    end

    // R3 R4: boundary sweep over every region window
    for (int j = 0; j < m_cnt; j++) begin
      load_chk(m_base[j] - 32'd1, 0, "R3 below base");
      load_chk(m_base[j], 0, "R3 at base");
      load_chk(m_base[j] + m_size[j] - 32'd1, 0, "R3 last byte");
      load_chk(m_base[j] + m_size[j], 0, "R4 past end");
    end
    load_chk(32'hC000_0004, 0, "R2 equal base first registered");
    load_chk(32'h3000_0000, 0, "R2 full table insert ignored");

    // R5: fetches bypass the table
    for (int j = 0; j < m_cnt; j++) load_chk(m_base[j] + 32'd8, 1, "R5 fetch");

    // R8: byte, half and word stores read back as words
    for (int b = 0; b < 4; b++) begin
      access(TCM_BASE + 32'h20 + 32'(b), 1'b1, 0, 0, 2'd0, 32'h11 << (8*b) | 32'hA5A5A5A5);
      model_store(TCM_BASE + 32'h20 + 32'(b), 2'd0, 32'h11 << (8*b) | 32'hA5A5A5A5);
    end
    access(TCM_BASE + 32'h26, 1'b1, 0, 0, 2'd1, 32'hBEEF_0000);
    model_store(TCM_BASE + 32'h26, 2'd1, 32'hBEEF_0000);
    access(TCM_BASE + 32'h28, 1'b1, 0, 0, 2'd2, 32'h1234_5678);
    model_store(TCM_BASE + 32'h28, 2'd2, 32'h1234_5678);
    load_chk(TCM_BASE + 32'h20, 0, "R8 byte lanes");
    load_chk(TCM_BASE + 32'h24, 0, "R8 half lanes");
    load_chk(TCM_BASE + 32'h28, 0, "R8 word");
    load_chk(TCM_BASE + 32'h4028, 0, "R8 index modulo depth");

    // R6: size/offset/debug sweep on tcm stores
    for (int s = 1; s <= 2; s++)
      for (int off = 0; off < 4; off++)
        for (int d = 0; d < 2; d++) begin
          logic [31:0] a = TCM_BASE + 32'h40 + 32'((s*8 + off*2 + d) * 4) - 32'h20 + 32'(off);
          logic [31:0] wd = 32'hC0DE_0000 + 32'(s*256 + off*16 + d);
          bit trap = ((off % (1 << s)) != 0) && (d == 0);
          access(a, 1'b1, 0, d[0], 2'(s), wd);
          if (trap) begin
            chk(r_lat == 1 && r_err && r_tv && r_tc == 4'd6 && r_ta == a, "R6 misaligned trap",
                {r_tc, 4'(r_lat), 24'(r_ta)}, {4'd6, 4'd1, 24'(a)});
            chk(r_dmm == 0 && r_de0 == 0 && r_de1 == 0 && !r_tv2 && !r_rdy,
                "R9 single trap cycle", {29'd0, r_tv2, r_rdy, 1'b0}, 32'h0);
          end else begin
            chk(r_lat == 3 && !r_err && !r_tv, "R6 aligned or debug store",
                {31'(r_lat), r_tv}, {31'd3, 1'b0});
            model_store(a, 2'(s), wd);
          end
          load_chk({a[31:2], 2'b00}, 0, "R6 tcm contents");
        end
    access(TCM_BASE + 32'h41, 1'b0, 0, 0, 2'd2, 32'h0);
    chk(r_lat == 3 && !r_err && !r_tv, "R6 misaligned load not checked", 32'(r_lat), 32'd3);

    // R7: target errors
    mm_err = 1;
    access(32'h0000_1000, 1'b0, 0, 0, 2'd2, 32'h0);
    chk(r_err && r_tv && r_tc == 4'd5 && r_ta == 32'h0000_1000 && !r_tv2, "R7 load fault",
        {r_tc, r_ta[27:0]}, {4'd5, 28'h0001000});
    access(32'h0000_1004, 1'b1, 0, 0, 2'd2, 32'h5);
    chk(r_err && r_tv && r_tc == 4'd7 && r_ta == 32'h0000_1004, "R7 store fault",
        {r_tc, r_ta[27:0]}, {4'd7, 28'h0001004});
    access(32'hC000_0010, 1'b0, 1, 0, 2'd2, 32'h0);
    chk(r_err && r_tv && r_tc == 4'd5 && r_dmm == 1, "R7 fetch fault", {28'd0, r_tc}, 32'd5);
    mm_err = 0;
    ext_err = 2'b01;
    access(32'hC000_0008, 1'b1, 0, 0, 2'd2, 32'h9);
    chk(r_err && r_tv && r_tc == 4'd7 && r_ta == 32'hC000_0008 && r_de0 == 1, "R7 ext store fault",
        {r_tc, r_ta[27:0]}, {4'd7, 28'h0000008});
    access(TCM_BASE + 32'h8, 1'b0, 0, 0, 2'd2, 32'h0);
    chk(!r_err && !r_tv, "R8 tcm never errors", {31'd0, r_err}, 32'd0);
    ext_err = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule